// File: doc/BRIEF.md
# Cell Protection Threshold and Delay Monitor

This block watches a six-cell stack for three conditions: a cell above its high-voltage limit, a cell below its low-voltage limit, and a temperature channel above its heat limit. Each conversion cycle delivers one 14-bit code per cell and per temperature channel, and a one-cycle strobe marks the moment the new set is valid. A condition raises its flag only after it has been present for the whole programmed qualification time. A single excursion shorter than that time leaves no trace.

Limits are given as step indices and qualification times as tick counts. When the configuration strobe is pulsed, the block turns each index into a 14-bit comparison code with a fixed-point multiply-add and latches it, together with a recovery level offset by the hysteresis margin. Flags are sticky. A flag drops only when a write-one-to-clear pulse arrives after the reading has moved back past the recovery level. A combined fault line ORs the flag groups that the enable mask selects.

Top module: `cell_prot_mon`

## Requirements
- R1: A cell whose code is strictly greater than the high limit trips its high flag (`ovFlags` bit = cell index). The limit code is 5291 + floor((idx*33862+128)/256), where idx is `ovLevel`. A code equal to the limit does not trip.
- R2: A cell whose code is strictly less than the low limit trips its low flag (`uvFlags`). The limit code is 1852 + floor((idx*67725+128)/256), where idx is `uvLevel`.
- R3: A temperature code strictly greater than 6536 + 65*`otLevel` trips its heat flag (`otFlags`). The qualification time is `otDelay` (all 8 bits) counted in 10 ms ticks.
- R4: For the high and low conditions, bits [6:0] of the delay input give the tick count. Bit 7 selects the tick: 0 for 100 us, 1 for 100 ms. One 100 us tick lasts `CLK_PER_100US` clocks.
- R5: Any sample that is not past the limit resets that channel's delay count. A condition held for less than the programmed time never trips.
- R6: A programmed count of zero trips on the first offending sample. The flag is visible two clock edges after the strobe edge.
- R7: Flags are sticky. A flag clears only on a clear pulse for its bit, and only once the channel has recovered. Without the pulse it stays set.
- R8: Recovery needs the code to reach the limit minus 132 codes (high), the limit plus 265 codes (low), or the limit minus limit>>3 (heat). A clear given while the reading sits between the limit and that level is ignored.
- R9: `faultAny` is 1 exactly when some flag is set in a group whose `faultMask` bit is 1. Bit 0 selects high, bit 1 low, bit 2 heat.
- R10: After reset all flags and `faultAny` are 0, the levels act as index 0 and the delays are zero.
- R11: Level and delay inputs take effect only on a `cfgWrite` pulse. Changing them without that pulse does not change any trip decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStrobe | input | 1 | New sample set valid this cycle |
| cellCodes | input | NCELL*CODE_W | Cell voltage codes, cell i at bits [i*14 +: 14] |
| tempCodes | input | NTEMP*CODE_W | Temperature codes, channel j at bits [j*14 +: 14] |
| cfgWrite | input | 1 | Latch levels and delays |
| ovLevel | input | 6 | High-voltage limit step index |
| uvLevel | input | 5 | Low-voltage limit step index |
| otLevel | input | 8 | Heat limit step index |
| ovDelay | input | 8 | High qualification: [7] unit, [6:0] count |
| uvDelay | input | 8 | Low qualification: [7] unit, [6:0] count |
| otDelay | input | 8 | Heat qualification in 10 ms ticks |
| faultMask | input | 3 | Group enables for faultAny |
| ovClear | input | NCELL | Write-one-to-clear for high flags |
| uvClear | input | NCELL | Write-one-to-clear for low flags |
| otClear | input | NTEMP | Write-one-to-clear for heat flags |
| ovFlags | output | NCELL | Sticky high-voltage flags |
| uvFlags | output | NCELL | Sticky low-voltage flags |
| otFlags | output | NTEMP | Sticky heat flags |
| faultAny | output | 1 | OR of the enabled flag groups |

## Verification
On every cycle the assertions check four things in each channel. A non-offending sample zeroes the count. The count moves only by one and only on its tick. A flag rises only from a pending condition whose count has reached the delay. A flag falls only on a clear pulse after recovery. They also check that the latched recovery levels sit on the correct side of their limits and that the fault line never rises without a flag behind it. The exact trip cycle at both tick units, the failure of a short glitch to trip, the ignored clear inside the hysteresis band and the ignored level change without a write can only be shown by the bench scenarios. Those scenarios are compared against a cycle-level model.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int OV_BASE_MV = 2000;
  localparam int OV_STEP_MV = 50;
  localparam int OV_HYST_MV = 50;
  localparam int UV_BASE_MV = 700;
  localparam int UV_STEP_MV = 100;
  localparam int UV_HYST_MV = 100;
  localparam int OT_HYST_SHIFT = 3;
  localparam int SUB_PER_10MS = 100;
  localparam int SUB_PER_100MS = 10;

  typedef struct packed {
    logic tick100us;
    logic tick10ms;
    logic tick100ms;
    logic cfgLoad;
    logic sample;
  } ctrlStrobe_t;
endpackage

// File: rtl/cpm_chan.sv
module cpm_chan #(
  parameter int CODE_W = 14,
  parameter int THR_W = 16,
  parameter int CNT_W = 8,
  parameter bit TRIP_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sample,
  input  logic              tick,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  input  logic [THR_W-1:0]  thr,
  input  logic [THR_W-1:0]  recLvl,
  input  logic [CNT_W-1:0]  dly,
  output logic              status
);
  logic pending, recovered;
  logic [CNT_W-1:0] cnt;
  logic [THR_W-1:0] codeExt;
  logic pastNow, recNow;

  assign codeExt = THR_W'(code);

  generate
    if (TRIP_HIGH) begin : g_high
      assign pastNow = codeExt > thr;
      assign recNow  = codeExt <= recLvl;
    end else begin : g_low
      assign pastNow = codeExt < thr;
      assign recNow  = codeExt >= recLvl;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      recovered <= 1'b1;
      cnt       <= '0;
      status    <= 1'b0;
    end else begin
      if (sample) begin
        pending <= pastNow;
        if (recNow) recovered <= 1'b1;
        else if (pastNow) recovered <= 1'b0;
      end
      if (sample && !pastNow) cnt <= '0;
      else if (pending && tick && cnt < dly) cnt <= cnt + 1'b1;
      if (pending && cnt >= dly) status <= 1'b1;
      else if (clr && recovered) status <= 1'b0;
    end
  end

  p_cnt_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sample && !pastNow) |=> (cnt == '0));
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((cnt != $past(cnt)) && (cnt != '0)) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) && $past(tick)));
  p_set_qualified_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status) |-> ($past(pending) && ($past(cnt) >= $past(dly))));
  p_clear_recovered_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status) |-> ($past(clr) && $past(recovered)));
endmodule

// File: rtl/cpm_ctrl.sv
module cpm_ctrl
  import cpm_pkg::*;
#(
  parameter int CLK_PER_100US = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleStrobe,
  input  logic        cfgWrite,
  output ctrlStrobe_t strb
);
  localparam int PRE_W = (CLK_PER_100US > 1) ? $clog2(CLK_PER_100US) : 1;
  localparam int MID_W = $clog2(SUB_PER_10MS);
  localparam int HI_W = $clog2(SUB_PER_100MS);

  logic [PRE_W-1:0] preCnt;
  logic [MID_W-1:0] midCnt;
  logic [HI_W-1:0]  hiCnt;
  logic t100us, t10ms, t100ms;

  assign t100us = (preCnt == PRE_W'(CLK_PER_100US - 1));
  assign t10ms  = t100us && (midCnt == MID_W'(SUB_PER_10MS - 1));
  assign t100ms = t10ms && (hiCnt == HI_W'(SUB_PER_100MS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      midCnt <= '0;
      hiCnt  <= '0;
    end else begin
      preCnt <= t100us ? '0 : preCnt + 1'b1;
      if (t100us) midCnt <= t10ms ? '0 : midCnt + 1'b1;
      if (t10ms) hiCnt <= t100ms ? '0 : hiCnt + 1'b1;
    end
  end

  assign strb = '{tick100us: t100us, tick10ms: t10ms, tick100ms: t100ms,
                  cfgLoad: cfgWrite, sample: sampleStrobe};

  p_hi_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick100ms |=> ((hiCnt == '0) && (midCnt == '0) && (preCnt == '0)));
  generate
    if (CLK_PER_100US > 1) begin : g_gap
      p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
        strb.tick100us |=> !strb.tick100us);
    end
  endgenerate
endmodule

// File: rtl/cpm_datapath.sv
module cpm_datapath
  import cpm_pkg::*;
#(
  parameter int NCELL = 6,
  parameter int NTEMP = 2,
  parameter int CODE_W = 14,
  parameter int CODE_LSB_NV = 378000,
  parameter int OV_IDX_W = 6,
  parameter int UV_IDX_W = 5,
  parameter int OT_IDX_W = 8,
  parameter int DLY_W = 8,
  parameter int OT_BASE_CODE = 6536,
  parameter int OT_STEP_CODE = 65
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strb,
  input  logic [NCELL*CODE_W-1:0] cellCodes,
  input  logic [NTEMP*CODE_W-1:0] tempCodes,
  input  logic [OV_IDX_W-1:0]     ovLevel,
  input  logic [UV_IDX_W-1:0]     uvLevel,
  input  logic [OT_IDX_W-1:0]     otLevel,
  input  logic [DLY_W-1:0]        ovDelay,
  input  logic [DLY_W-1:0]        uvDelay,
  input  logic [DLY_W-1:0]        otDelay,
  input  logic [NCELL-1:0]        ovClear,
  input  logic [NCELL-1:0]        uvClear,
  input  logic [NTEMP-1:0]        otClear,
  output logic [NCELL-1:0]        ovFlags,
  output logic [NCELL-1:0]        uvFlags,
  output logic [NTEMP-1:0]        otFlags
);
  localparam int THR_W = CODE_W + 2;
  localparam longint LSB = longint'(CODE_LSB_NV);
  localparam logic [31:0] OV_BASE = 32'((longint'(OV_BASE_MV) * 1000000 + LSB / 2) / LSB);
  localparam logic [31:0] OV_STEP_Q8 = 32'((longint'(OV_STEP_MV) * 256000000 + LSB / 2) / LSB);
  localparam logic [31:0] OV_HYST = 32'((longint'(OV_HYST_MV) * 1000000 + LSB / 2) / LSB);
  localparam logic [31:0] UV_BASE = 32'((longint'(UV_BASE_MV) * 1000000 + LSB / 2) / LSB);
  localparam logic [31:0] UV_STEP_Q8 = 32'((longint'(UV_STEP_MV) * 256000000 + LSB / 2) / LSB);
  localparam logic [31:0] UV_HYST = 32'((longint'(UV_HYST_MV) * 1000000 + LSB / 2) / LSB);
  localparam logic [31:0] OT_BASE = 32'(OT_BASE_CODE);
  localparam logic [31:0] OT_STEP = 32'(OT_STEP_CODE);
  localparam logic [THR_W-1:0] OT_REC0 = THR_W'(OT_BASE - (OT_BASE >> OT_HYST_SHIFT));

  logic [THR_W-1:0] ovThr, ovRec, uvThr, uvRec, otThr, otRec;
  logic [THR_W-1:0] ovThrCalc, uvThrCalc, otThrCalc;
  logic [DLY_W-1:0] ovDly, uvDly, otDly;
  logic ovUnit, uvUnit;
  logic [31:0] ovProd, uvProd, otProd;

  always_comb begin
    ovProd = 32'(ovLevel) * OV_STEP_Q8 + 32'd128;
    uvProd = 32'(uvLevel) * UV_STEP_Q8 + 32'd128;
    otProd = 32'(otLevel) * OT_STEP;
    ovThrCalc = THR_W'(OV_BASE + (ovProd >> 8));
    uvThrCalc = THR_W'(UV_BASE + (uvProd >> 8));
    otThrCalc = THR_W'(OT_BASE + otProd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovThr  <= THR_W'(OV_BASE);
      ovRec  <= THR_W'(OV_BASE - OV_HYST);
      uvThr  <= THR_W'(UV_BASE);
      uvRec  <= THR_W'(UV_BASE + UV_HYST);
      otThr  <= THR_W'(OT_BASE);
      otRec  <= OT_REC0;
      ovDly  <= '0;
      uvDly  <= '0;
      otDly  <= '0;
      ovUnit <= 1'b0;
      uvUnit <= 1'b0;
    end else if (strb.cfgLoad) begin
      ovThr  <= ovThrCalc;
      ovRec  <= ovThrCalc - THR_W'(OV_HYST);
      uvThr  <= uvThrCalc;
      uvRec  <= uvThrCalc + THR_W'(UV_HYST);
      otThr  <= otThrCalc;
      otRec  <= otThrCalc - (otThrCalc >> OT_HYST_SHIFT);
      ovDly  <= {1'b0, ovDelay[DLY_W-2:0]};
      uvDly  <= {1'b0, uvDelay[DLY_W-2:0]};
      otDly  <= otDelay;
      ovUnit <= ovDelay[DLY_W-1];
      uvUnit <= uvDelay[DLY_W-1];
    end
  end

  logic ovTick, uvTick;
  assign ovTick = ovUnit ? strb.tick100ms : strb.tick100us;
  assign uvTick = uvUnit ? strb.tick100ms : strb.tick100us;

  generate
    for (genvar i = 0; i < NCELL; i++) begin : g_cell
      cpm_chan #(.CODE_W(CODE_W), .THR_W(THR_W), .CNT_W(DLY_W), .TRIP_HIGH(1'b1)) u_ov (
        .clk(clk), .rstN(rstN), .sample(strb.sample), .tick(ovTick), .clr(ovClear[i]),
        .code(cellCodes[i*CODE_W +: CODE_W]), .thr(ovThr), .recLvl(ovRec), .dly(ovDly),
        .status(ovFlags[i]));
      cpm_chan #(.CODE_W(CODE_W), .THR_W(THR_W), .CNT_W(DLY_W), .TRIP_HIGH(1'b0)) u_uv (
        .clk(clk), .rstN(rstN), .sample(strb.sample), .tick(uvTick), .clr(uvClear[i]),
        .code(cellCodes[i*CODE_W +: CODE_W]), .thr(uvThr), .recLvl(uvRec), .dly(uvDly),
        .status(uvFlags[i]));
    end
    for (genvar j = 0; j < NTEMP; j++) begin : g_temp
      cpm_chan #(.CODE_W(CODE_W), .THR_W(THR_W), .CNT_W(DLY_W), .TRIP_HIGH(1'b1)) u_ot (
        .clk(clk), .rstN(rstN), .sample(strb.sample), .tick(strb.tick10ms), .clr(otClear[j]),
        .code(tempCodes[j*CODE_W +: CODE_W]), .thr(otThr), .recLvl(otRec), .dly(otDly),
        .status(otFlags[j]));
    end
  endgenerate

  p_ov_band_r8: assert property (@(posedge clk) disable iff (!rstN) ovRec < ovThr);
  p_uv_band_r8: assert property (@(posedge clk) disable iff (!rstN) uvRec > uvThr);
  p_ot_band_r8: assert property (@(posedge clk) disable iff (!rstN) otRec < otThr);
endmodule

// File: rtl/cell_prot_mon.sv
module cell_prot_mon
  import cpm_pkg::*;
#(
  parameter int NCELL = 6,
  parameter int NTEMP = 2,
  parameter int CODE_W = 14,
  parameter int CLK_PER_100US = 10000,
  parameter int CODE_LSB_NV = 378000,
  parameter int OV_IDX_W = 6,
  parameter int UV_IDX_W = 5,
  parameter int OT_IDX_W = 8,
  parameter int DLY_W = 8,
  parameter int OT_BASE_CODE = 6536,
  parameter int OT_STEP_CODE = 65
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleStrobe,
  input  logic [NCELL*CODE_W-1:0] cellCodes,
  input  logic [NTEMP*CODE_W-1:0] tempCodes,
  input  logic                    cfgWrite,
  input  logic [OV_IDX_W-1:0]     ovLevel,
  input  logic [UV_IDX_W-1:0]     uvLevel,
  input  logic [OT_IDX_W-1:0]     otLevel,
  input  logic [DLY_W-1:0]        ovDelay,
  input  logic [DLY_W-1:0]        uvDelay,
  input  logic [DLY_W-1:0]        otDelay,
  input  logic [2:0]              faultMask,
  input  logic [NCELL-1:0]        ovClear,
  input  logic [NCELL-1:0]        uvClear,
  input  logic [NTEMP-1:0]        otClear,
  output logic [NCELL-1:0]        ovFlags,
  output logic [NCELL-1:0]        uvFlags,
  output logic [NTEMP-1:0]        otFlags,
  output logic                    faultAny
);
  ctrlStrobe_t strb;

  cpm_ctrl #(.CLK_PER_100US(CLK_PER_100US)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .cfgWrite(cfgWrite), .strb(strb));

  cpm_datapath #(
    .NCELL(NCELL), .NTEMP(NTEMP), .CODE_W(CODE_W), .CODE_LSB_NV(CODE_LSB_NV),
    .OV_IDX_W(OV_IDX_W), .UV_IDX_W(UV_IDX_W), .OT_IDX_W(OT_IDX_W), .DLY_W(DLY_W),
    .OT_BASE_CODE(OT_BASE_CODE), .OT_STEP_CODE(OT_STEP_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cellCodes(cellCodes), .tempCodes(tempCodes),
    .ovLevel(ovLevel), .uvLevel(uvLevel), .otLevel(otLevel),
    .ovDelay(ovDelay), .uvDelay(uvDelay), .otDelay(otDelay),
    .ovClear(ovClear), .uvClear(uvClear), .otClear(otClear),
    .ovFlags(ovFlags), .uvFlags(uvFlags), .otFlags(otFlags));

  assign faultAny = ((|ovFlags) & faultMask[0]) | ((|uvFlags) & faultMask[1]) |
                    ((|otFlags) & faultMask[2]);

  p_fault_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    faultAny |-> ((ovFlags != '0) || (uvFlags != '0) || (otFlags != '0)));
  p_fault_masked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (faultMask == 3'b000) |-> !faultAny);
endmodule

// File: tb/cell_prot_mon_tb.sv
module cell_prot_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCELL = 6;
  localparam int NTEMP = 2;
  localparam int CW = 14;
  localparam int PRESCALE = 4;
  localparam int NCH = 2 * NCELL + NTEMP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStrobe = 1'b0;
  logic cfgWrite = 1'b0;
  logic [CW-1:0] cellV [NCELL];
  logic [CW-1:0] tempV [NTEMP];
  logic [NCELL*CW-1:0] cellCodes;
  logic [NTEMP*CW-1:0] tempCodes;
  logic [5:0] ovLevel = '0;
  logic [4:0] uvLevel = '0;
  logic [7:0] otLevel = '0;
  logic [7:0] ovDelay = '0, uvDelay = '0, otDelay = '0;
  logic [2:0] faultMask = 3'b111;
  logic [NCELL-1:0] ovClear = '0, uvClear = '0;
  logic [NTEMP-1:0] otClear = '0;
  logic [NCELL-1:0] ovFlags, uvFlags;
  logic [NTEMP-1:0] otFlags;
  logic faultAny;

  always_comb begin
    for (int i = 0; i < NCELL; i++) cellCodes[i*CW +: CW] = cellV[i];
    for (int j = 0; j < NTEMP; j++) tempCodes[j*CW +: CW] = tempV[j];
  end

  cell_prot_mon #(.NCELL(NCELL), .NTEMP(NTEMP), .CODE_W(CW), .CLK_PER_100US(PRESCALE)) dut_i (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .cellCodes(cellCodes),
    .tempCodes(tempCodes), .cfgWrite(cfgWrite), .ovLevel(ovLevel), .uvLevel(uvLevel),
    .otLevel(otLevel), .ovDelay(ovDelay), .uvDelay(uvDelay), .otDelay(otDelay),
    .faultMask(faultMask), .ovClear(ovClear), .uvClear(uvClear), .otClear(otClear),
    .ovFlags(ovFlags), .uvFlags(uvFlags), .otFlags(otFlags), .faultAny(faultAny));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad = 0;

  function automatic int ovThrOf(int idx); return 5291 + (idx * 33862 + 128) / 256; endfunction
  function automatic int uvThrOf(int idx); return 1852 + (idx * 67725 + 128) / 256; endfunction
  function automatic int otThrOf(int idx); return 6536 + 65 * idx; endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model
  int mThr [3], mRec [3], mDly [3];
  bit mUnit [2];
  bit mPend [NCH], mRecov [NCH], mStat [NCH];
  int mCnt [NCH];
  int n;

  task automatic modelCfgReset();
    mThr[0] = ovThrOf(0); mRec[0] = mThr[0] - 132;
    mThr[1] = uvThrOf(0); mRec[1] = mThr[1] + 265;
    mThr[2] = otThrOf(0); mRec[2] = mThr[2] - (mThr[2] >> 3);
    for (int k = 0; k < 3; k++) mDly[k] = 0;
    mUnit[0] = 0; mUnit[1] = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      modelCfgReset();
      for (int c = 0; c < NCH; c++) begin
        mPend[c] = 0; mRecov[c] = 1; mStat[c] = 0; mCnt[c] = 0;
      end
      n = 0;
    end else begin
      bit t100us, t10ms, t100ms;
      t100us = (n % PRESCALE) == PRESCALE - 1;
      t10ms = (n % (100 * PRESCALE)) == 100 * PRESCALE - 1;
      t100ms = (n % (1000 * PRESCALE)) == 1000 * PRESCALE - 1;
      for (int c = 0; c < NCH; c++) begin
        int kind, code;
        bit tk, clr, past, recN, nPend, nRecov, nStat;
        int nCnt;
        if (c < NCELL) begin
          kind = 0; code = int'(cellV[c]); clr = ovClear[c];
          tk = mUnit[0] ? t100ms : t100us;
        end else if (c < 2 * NCELL) begin
          kind = 1; code = int'(cellV[c-NCELL]); clr = uvClear[c-NCELL];
          tk = mUnit[1] ? t100ms : t100us;
        end else begin
          kind = 2; code = int'(tempV[c-2*NCELL]); clr = otClear[c-2*NCELL];
          tk = t10ms;
        end
        past = (kind == 1) ? (code < mThr[1]) : (code > mThr[kind]);
        recN = (kind == 1) ? (code >= mRec[1]) : (code <= mRec[kind]);
        nPend = mPend[c]; nRecov = mRecov[c]; nCnt = mCnt[c]; nStat = mStat[c];
        if (sampleStrobe) begin
          nPend = past;
          if (recN) nRecov = 1; else if (past) nRecov = 0;
        end
        if (sampleStrobe && !past) nCnt = 0;
        else if (mPend[c] && tk && mCnt[c] < mDly[kind]) nCnt = mCnt[c] + 1;
        if (mPend[c] && mCnt[c] >= mDly[kind]) nStat = 1;
        else if (clr && mRecov[c]) nStat = 0;
        mPend[c] = nPend; mRecov[c] = nRecov; mCnt[c] = nCnt; mStat[c] = nStat;
      end
      if (cfgWrite) begin
        mThr[0] = ovThrOf(int'(ovLevel)); mRec[0] = mThr[0] - 132;
        mThr[1] = uvThrOf(int'(uvLevel)); mRec[1] = mThr[1] + 265;
        mThr[2] = otThrOf(int'(otLevel)); mRec[2] = mThr[2] - (mThr[2] >> 3);
        mDly[0] = int'(ovDelay[6:0]); mUnit[0] = ovDelay[7];
        mDly[1] = int'(uvDelay[6:0]); mUnit[1] = uvDelay[7];
        mDly[2] = int'(otDelay);
      end
      n++;
      #1;
      begin
        logic [NCELL-1:0] eOv, eUv;
        logic [NTEMP-1:0] eOt;
        logic eAny;
        for (int i = 0; i < NCELL; i++) begin eOv[i] = mStat[i]; eUv[i] = mStat[NCELL+i]; end
        for (int j = 0; j < NTEMP; j++) eOt[j] = mStat[2*NCELL+j];
        eAny = ((|eOv) & faultMask[0]) | ((|eUv) & faultMask[1]) | ((|eOt) & faultMask[2]);
        check("R1", "model ovFlags", int'(ovFlags), int'(eOv));
        check("R2", "model uvFlags", int'(uvFlags), int'(eUv));
        check("R3", "model otFlags", int'(otFlags), int'(eOt));
        check("R9", "model faultAny", int'(faultAny), int'(eAny));
      end
    end
  end

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic sampleN(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) sampleStrobe = 1'b1;
      @(negedge clk) sampleStrobe = 1'b0;
      cyc(6);
    end
  endtask

  task automatic writeCfg();
    @(negedge clk) cfgWrite = 1'b1;
    @(negedge clk) cfgWrite = 1'b0;
  endtask

  task automatic clearAll();
    @(negedge clk) begin ovClear = '1; uvClear = '1; otClear = '1; end
    @(negedge clk) begin ovClear = '0; uvClear = '0; otClear = '0; end
    cyc(1);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NCELL; i++) cellV[i] = 14'd7000;
    for (int j = 0; j < NTEMP; j++) tempV[j] = 14'd5000;
    cyc(3);
    @(negedge clk) rstN = 1'b1;
    cyc(2);
    // R10 reset state
    check("R10", "ovFlags after reset", int'(ovFlags), 0);
    check("R10", "uvFlags after reset", int'(uvFlags), 0);
    check("R10", "otFlags after reset", int'(otFlags), 0);
    check("R10", "faultAny after reset", int'(faultAny), 0);

    ovLevel = 6'd30; uvLevel = 5'd10; otLevel = 8'd50;
    ovDelay = 8'd5; uvDelay = 8'd0; otDelay = 8'd1;
    writeCfg();
    sampleN(4);
    check("R1", "quiet stack ovFlags", int'(ovFlags), 0);
    check("R2", "quiet stack uvFlags", int'(uvFlags), 0);

    // R5 glitch shorter than delay
    cellV[2] = 14'(ovThrOf(30) + 1);
    sampleN(1);
    cellV[2] = 14'd7000;
    sampleN(5);
    check("R5", "glitch ovFlags", int'(ovFlags), 0);

    // R1 and R4 trip at 100 us unit, equal code does not trip
    cellV[3] = 14'(ovThrOf(30));
    cellV[2] = 14'(ovThrOf(30) + 1);
    sampleN(2);
    check("R4", "before 5 ticks ovFlags", int'(ovFlags), 0);
    sampleN(6);
    check("R1", "held over limit ovFlags", int'(ovFlags), 32'h04);

    // R8 clear inside hysteresis band ignored, R7 sticky
    cellV[2] = 14'(ovThrOf(30) - 59);
    sampleN(2);
    clearAll();
    check("R8", "clear inside band ovFlags", int'(ovFlags), 32'h04);
    cellV[2] = 14'(ovThrOf(30) - 132);
    sampleN(2);
    check("R7", "recovered no clear ovFlags", int'(ovFlags), 32'h04);
    clearAll();
    check("R7", "recovered and cleared ovFlags", int'(ovFlags), 0);
    cellV[2] = 14'd7000; cellV[3] = 14'd7000;

    // R6 zero delay, R9 masking
    faultMask = 3'b101;
    cellV[0] = 14'(uvThrOf(10) - 1);
    @(negedge clk) sampleStrobe = 1'b1;
    @(negedge clk) sampleStrobe = 1'b0;
    @(negedge clk);
    check("R6", "zero delay uvFlags", int'(uvFlags), 1);
    check("R9", "masked faultAny", int'(faultAny), 0);
    faultMask = 3'b010;
    cyc(1);
    check("R9", "enabled faultAny", int'(faultAny), 1);
    cellV[0] = 14'(uvThrOf(10) + 265);
    sampleN(1);
    clearAll();
    check("R8", "low recovered cleared uvFlags", int'(uvFlags), 0);
    faultMask = 3'b111;
    cellV[0] = 14'd7000;

    // R11 level change without write
    ovLevel = 6'd0;
    cellV[1] = 14'd6000;
    sampleN(3);
    check("R11", "unlatched level ovFlags", int'(ovFlags), 0);
    cellV[1] = 14'd7000;
    ovLevel = 6'd30;

    // R4 100 ms unit
    ovDelay = 8'h82;
    writeCfg();
    cellV[4] = 14'd9300;
    sampleN(500);
    check("R4", "100ms unit early ovFlags", int'(ovFlags), 0);
    sampleN(600);
    check("R4", "100ms unit late ovFlags", int'(ovFlags), 32'h10);
    cellV[4] = 14'd7000;
    sampleN(1);
    clearAll();
    check("R7", "cleared after 100ms trip", int'(ovFlags), 0);

    // R3 heat with 10 ms unit, R8 heat hysteresis
    tempV[1] = 14'(otThrOf(50) + 1);
    sampleN(60);
    check("R3", "heat otFlags", int'(otFlags), 2);
    tempV[1] = 14'd8600;
    sampleN(1);
    clearAll();
    check("R8", "heat clear inside band", int'(otFlags), 2);
    tempV[1] = 14'(otThrOf(50) - (otThrOf(50) >> 3));
    sampleN(1);
    clearAll();
    check("R8", "heat recovered cleared", int'(otFlags), 0);
    check("R9", "faultAny idle at end", int'(faultAny), 0);

    cyc(4);
    finishRun();
  end
endmodule